// File: doc/BRIEF.md
# Programmable Loop Divider and Phase Detector

This block is the digital core of a frequency-synthesis loop. A loadable 13-bit counter divides a prescaled oscillator clock by the loaded code plus one. The prescaled clocks arrive as single-cycle clock-enable ticks on the system clock. A band input picks the source: the low band takes ticks from the divide-by-8 prescaler, and the high band takes ticks from the divide-by-64 prescaler. The band input also picks the reference tick stream, which is 10 kHz on the low band and 25 kHz on the high band.

A two-state-memory phase-frequency detector compares each divider output event with the selected reference event. It drives up and down requests for an external charge pump. A pump-enable input, active high, forces both requests off and raises a high-impedance flag. This lets an automatic frequency control loop take over. A new divide code is taken only at terminal count. A change of band restarts the divider and clears the detector.

The divider is a two-state machine:
- `DV_LOAD` copies the code and zeroes the count, then moves to `DV_RUN`.
- `DV_RUN` counts the selected ticks. At terminal count it stays in `DV_RUN`, reloads the code and emits an event.
- A band change sends the divider from any state to `DV_LOAD`.

The detector has four states: `PD_IDLE`, `PD_UP`, `PD_DN` and `PD_CLR`. Its transitions are:
- `PD_IDLE` to `PD_UP` on a reference event alone.
- `PD_IDLE` to `PD_DN` on a divider event alone.
- `PD_IDLE` to `PD_CLR` when both events arrive together.
- `PD_UP` to `PD_CLR` on a divider event.
- `PD_DN` to `PD_CLR` on a reference event.
- `PD_CLR` to `PD_UP`, `PD_DN` or `PD_IDLE`, according to which single event, if any, arrives in that cycle. When both events arrive in that cycle, it goes to `PD_IDLE`.
- A band change sends the detector from any state to `PD_IDLE`.

Top module: `pll_loop_core`

## Requirements
- R1: After reset, `pump_up`, `pump_dn` and `div_pulse` are 0. `pump_hiz` is the inverse of `pump_en`.
- R2: With code N on `div_code`, `div_pulse` is high for one cycle on the (N+1)-th selected tick of every period. It is seen in the cycle after that tick. With N=0, every tick gives a pulse.
- R3: With `band_fm`=1, only `fm_tick` and `ref_fm_tick` are used. With `band_fm`=0, only `am_tick` and `ref_am_tick` are used. Ticks on the other band's inputs change no output.
- R4: A new `div_code` is taken only at terminal count. A change in the middle of a period neither shortens nor lengthens that period, and the next period uses the new code.
- R5: A reference event with no divider event pending raises `pump_up` alone, two cycles after the reference tick. Further reference ticks keep it there until a divider event arrives.
- R6: A divider event with no reference event pending raises `pump_dn` alone, two cycles after the divider's input tick.
- R7: When both events are pending, `pump_up` and `pump_dn` are both high for exactly one cycle, and then both fall. This also applies when both events arrive in the same cycle.
- R8: `pump_en`=0 forces `pump_hiz`=1 and `pump_up`=`pump_dn`=0 in the same cycle. The detector state is kept, so a pending request reappears when `pump_en` returns to 1.
- R9: A change of `band_fm` clears the detector at the next edge. The divider restarts from zero, so the first period on the new band is a full N+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| band_fm | input | 1 | Band select: 1 high band, 0 low band |
| am_tick | input | 1 | Low-band prescaler output tick (clock enable) |
| fm_tick | input | 1 | High-band prescaler output tick (clock enable) |
| ref_am_tick | input | 1 | 10 kHz reference tick |
| ref_fm_tick | input | 1 | 25 kHz reference tick |
| div_code | input | 13 | Divide code N; the ratio is N+1 |
| pump_en | input | 1 | Pump enable; 0 forces high impedance |
| pump_up | output | 1 | Request charge-pump source current |
| pump_dn | output | 1 | Request charge-pump sink current |
| pump_hiz | output | 1 | Charge pump held in high impedance |
| div_pulse | output | 1 | One-cycle divider output event |

## Verification
Two functions can fall in the same cycle: the reference event and the divider event. Both travel through one register stage, so they can reach the detector together. The bench provokes this by raising `ref_am_tick` and `am_tick` in the same cycle with N=0. It expects a single cycle with both requests high, followed by both low. A second collision is a band change against a pending up request: the bench flips `band_fm` while in `PD_UP` and judges that the request falls at that edge.

// File: rtl/pll_loop_pkg.sv
package pll_loop_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2,
        PD_CLR  = 2'd3
    } pfd_state_e;

    typedef enum logic {
        DV_LOAD = 1'b0,
        DV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/pll_div_ctr.sv
module pll_div_ctr
    import pll_loop_pkg::*;
#(
    parameter int CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code_in,
    output logic              div_evt
);

    div_state_e        st, st_n;
    logic [CODE_W-1:0] cnt, cnt_n;
    logic [CODE_W-1:0] code_q, code_n;
    logic              evt_n;
    logic              term;

    assign term = (cnt == code_q);

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        code_n = code_q;
        evt_n  = 1'b0;
        if (restart) begin
            st_n  = DV_LOAD;
            cnt_n = '0;
        end else begin
            unique case (st)
                DV_LOAD: begin
                    code_n = code_in;
                    cnt_n  = '0;
                    st_n   = DV_RUN;
                end
                DV_RUN: begin
                    if (tick) begin
                        if (term) begin
                            cnt_n  = '0;
                            code_n = code_in;
                            evt_n  = 1'b1;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= DV_LOAD;
            cnt     <= '0;
            code_q  <= '0;
            div_evt <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            code_q  <= code_n;
            div_evt <= evt_n;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DV_RUN) |-> (cnt <= code_q));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DV_RUN && !restart && !(tick && term)) |=> $stable(code_q));

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
    import pll_loop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic up,
    output logic dn
);

    pfd_state_e st, st_n;

    always_comb begin
        st_n = st;
        if (clear) begin
            st_n = PD_IDLE;
        end else begin
            unique case (st)
                PD_IDLE: begin
                    if (ref_evt && fb_evt) st_n = PD_CLR;
                    else if (ref_evt)      st_n = PD_UP;
                    else if (fb_evt)       st_n = PD_DN;
                end
                PD_UP: begin
                    if (fb_evt) st_n = PD_CLR;
                end
                PD_DN: begin
                    if (ref_evt) st_n = PD_CLR;
                end
                PD_CLR: begin
                    if (ref_evt && !fb_evt)      st_n = PD_UP;
                    else if (fb_evt && !ref_evt) st_n = PD_DN;
                    else                         st_n = PD_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PD_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        up = (st == PD_UP) || (st == PD_CLR);
        dn = (st == PD_DN) || (st == PD_CLR);
    end

    // R7
    overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> !(up && dn));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!up && !dn));

endmodule

// File: rtl/pll_loop_core.sv
module pll_loop_core
    import pll_loop_pkg::*;
#(
    parameter int CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              band_fm,
    input  logic              am_tick,
    input  logic              fm_tick,
    input  logic              ref_am_tick,
    input  logic              ref_fm_tick,
    input  logic [CODE_W-1:0] div_code,
    input  logic              pump_en,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              pump_hiz,
    output logic              div_pulse
);

    logic band_q;
    logic band_chg;
    logic tick_sel;
    logic ref_evt;
    logic div_evt;
    logic pfd_up;
    logic pfd_dn;

    assign band_chg = band_fm ^ band_q;
    assign tick_sel = band_fm ? fm_tick : am_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q  <= 1'b0;
            ref_evt <= 1'b0;
        end else begin
            band_q  <= band_fm;
            ref_evt <= band_chg ? 1'b0 : (band_fm ? ref_fm_tick : ref_am_tick);
        end
    end

    pll_div_ctr #(.CODE_W(CODE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (band_chg),
        .tick    (tick_sel),
        .code_in (div_code),
        .div_evt (div_evt)
    );

    pll_pfd u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (band_chg),
        .ref_evt (ref_evt),
        .fb_evt  (div_evt),
        .up      (pfd_up),
        .dn      (pfd_dn)
    );

    assign pump_up   = pump_en & pfd_up;
    assign pump_dn   = pump_en & pfd_dn;
    assign pump_hiz  = ~pump_en;
    assign div_pulse = div_evt;

    // R8
    hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en |-> (pump_hiz && !pump_up && !pump_dn));

endmodule

// File: tb/sim_pll_loop_core.sv
module sim_pll_loop_core;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int V_BAND [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int V_CODE [NV] = '{0, 2, 4, 6, 9, 1};
    localparam int V_TICKS[NV] = '{5, 9, 12, 20, 10, 7};
    localparam int V_EXP  [NV] = '{5, 3, 2, 2, 1, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        band_fm = 1'b0;
    logic        am_tick = 1'b0;
    logic        fm_tick = 1'b0;
    logic        ref_am_tick = 1'b0;
    logic        ref_fm_tick = 1'b0;
    logic [12:0] div_code = '0;
    logic        pump_en = 1'b1;
    logic        pump_up, pump_dn, pump_hiz, div_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_loop_core u0 (
        .clk(clk), .rst_n(rst_n), .band_fm(band_fm),
        .am_tick(am_tick), .fm_tick(fm_tick),
        .ref_am_tick(ref_am_tick), .ref_fm_tick(ref_fm_tick),
        .div_code(div_code), .pump_en(pump_en),
        .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .div_pulse(div_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        step();
        step();
    endtask

    task automatic do_tick(input bit fm, output bit p);
        if (fm) fm_tick = 1'b1;
        else    am_tick = 1'b1;
        step();
        am_tick = 1'b0;
        fm_tick = 1'b0;
        p = div_pulse;
    endtask

    task automatic ref_tick(input bit fm);
        if (fm) ref_fm_tick = 1'b1;
        else    ref_am_tick = 1'b1;
        step();
        ref_am_tick = 1'b0;
        ref_fm_tick = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit p;
        int cnt;
        @(negedge clk);

        // R1 reset state
        do_reset();
        chk("R1", "pump_up", pump_up, 0);
        chk("R1", "pump_dn", pump_dn, 0);
        chk("R1", "div_pulse", div_pulse, 0);
        chk("R1", "pump_hiz", pump_hiz, 0);

        // R2 / R3 vector table: divide ratio on both bands
        for (int v = 0; v < NV; v++) begin
            int pulses;
            int mism;
            band_fm = V_BAND[v][0];
            div_code = 13'(V_CODE[v]);
            do_reset();
            pulses = 0;
            mism = 0;
            for (int k = 0; k < V_TICKS[v]; k++) begin
                do_tick(band_fm, p);
                pulses += int'(p);
                if (int'(p) != int'(((k + 1) % (V_CODE[v] + 1)) == 0)) mism++;
            end
            chk("R2", "pulse count", pulses, V_EXP[v]);
            chk("R2", "pulse placement errors", mism, 0);
        end

        // R3 band isolation
        band_fm = 1'b1; div_code = '0;
        do_reset();
        ref_tick(1'b0); step();
        chk("R3", "up from unselected ref", pump_up, 0);
        ref_tick(1'b1); step();
        chk("R3", "up from selected ref", pump_up, 1);
        do_tick(1'b0, p);
        chk("R3", "pulse from unselected tick", p, 0);
        do_tick(1'b1, p);
        chk("R3", "pulse from selected tick", p, 1);

        // R5 / R7 / R6 detector sequences
        band_fm = 1'b0; div_code = '0;
        do_reset();
        ref_tick(1'b0); step();
        chk("R5", "up after ref", pump_up, 1);
        chk("R5", "dn after ref", pump_dn, 0);
        ref_tick(1'b0); step();
        chk("R5", "up after second ref", pump_up, 1);
        do_tick(1'b0, p); step();
        chk("R7", "up in overlap", pump_up, 1);
        chk("R7", "dn in overlap", pump_dn, 1);
        step();
        chk("R7", "up after overlap", pump_up, 0);
        chk("R7", "dn after overlap", pump_dn, 0);
        do_tick(1'b0, p); step();
        chk("R6", "dn after div", pump_dn, 1);
        chk("R6", "up after div", pump_up, 0);
        ref_tick(1'b0); step(); step();
        chk("R6", "dn cleared", pump_dn, 0);

        // R7 simultaneous events
        ref_am_tick = 1'b1; am_tick = 1'b1;
        step();
        ref_am_tick = 1'b0; am_tick = 1'b0;
        step();
        chk("R7", "both high on collision", int'(pump_up && pump_dn), 1);
        step();
        chk("R7", "both low after collision", int'(pump_up || pump_dn), 0);

        // R8 pump enable
        ref_tick(1'b0); step();
        pump_en = 1'b0;
        #1;
        chk("R8", "hiz", pump_hiz, 1);
        chk("R8", "up forced off", pump_up, 0);
        step(); step();
        pump_en = 1'b1;
        #1;
        chk("R8", "up restored", pump_up, 1);

        // R9 band change clears detector
        band_fm = 1'b1;
        step();
        chk("R9", "up cleared by band change", pump_up, 0);

        // R9 divider restart
        band_fm = 1'b0; div_code = 13'd3;
        do_reset();
        do_tick(1'b0, p);
        do_tick(1'b0, p);
        band_fm = 1'b1;
        step(); step(); step();
        cnt = 0;
        p = 0;
        for (int k = 0; k < 10 && !p; k++) begin
            do_tick(1'b1, p);
            cnt++;
        end
        chk("R9", "ticks to first pulse after band change", cnt, 4);

        // R4 code change mid-period
        band_fm = 1'b0; div_code = 13'd4;
        do_reset();
        do_tick(1'b0, p);
        do_tick(1'b0, p);
        div_code = 13'd1;
        cnt = 2;
        p = 0;
        for (int k = 0; k < 10 && !p; k++) begin
            do_tick(1'b0, p);
            cnt++;
        end
        chk("R4", "old period length", cnt, 5);
        cnt = 0;
        p = 0;
        for (int k = 0; k < 10 && !p; k++) begin
            do_tick(1'b0, p);
            cnt++;
        end
        chk("R4", "new period length", cnt, 2);

        report();
    end

endmodule